// File: doc/BRIEF.md
# Reed-Solomon (528,514) Systematic Encoder over GF(2^10)

This block turns a stream of 10-bit message symbols into Reed-Solomon codewords of 528 symbols, one symbol per clock. Each codeword carries 514 message symbols followed by 14 check symbols. The code corrects up to 7 symbol errors. The message symbols leave the block unchanged, one cycle after they are taken in. While they pass, they also feed a division register. Once the last message symbol is through, the 14 check symbols follow at once. These check symbols are the remainder of the message polynomial divided by the code generator.

The field is built on the primitive polynomial x^10 + x^3 + 1. The generator is the product of (x + alpha^j) for j = 0 to 13, where alpha is the primitive element. The generator coefficients are worked out from these two facts when the design is elaborated. The feedback path uses one constant field multiplier for each coefficient. A producer marks the first symbol of each codeword with a start strobe. A start strobe that arrives before a codeword is complete raises a framing error and begins a new codeword.

Top module: `rs528_encoder`

## Requirements
- R1: While reset is active and in the first cycle after it, outValid, outParity and frameErr are 0.
- R2: A symbol accepted at a clock edge appears on outData after the next edge, with outValid=1 and outParity=0, and its value is unchanged.
- R3: After the 514th message symbol of a codeword is output, exactly 14 symbols with outValid=1 and outParity=1 follow on the next 14 consecutive cycles. Then outValid drops, unless a new codeword is already running.
- R4: Take the 528 output symbols in output order, with the first symbol as the coefficient of x^527. This polynomial is a multiple of the product of (x + alpha^j) for j=0..13, over the field of polynomial x^10+x^3+1 with alpha = 0x002. Its 14 syndromes are therefore zero.
- R5: Send the message 1023, 1022, ..., 510. The check symbols come out in this order: 0x1c3, 0x3b8, 0x2a2, 0x08c, 0x21b, 0x11f, 0x1cc, 0x1b6, 0x22f, 0x373, 0x21e, 0x375, 0x3a2, 0x0bf.
- R6: With no codeword in progress, a symbol with inValid=1 and inStart=1 starts a codeword from a cleared remainder. A symbol with inValid=1 and inStart=0 is ignored and produces no output.
- R7: If inValid=1 and inStart=1 while fewer than 514 message symbols have been accepted, the codeword restarts with that symbol as its first symbol and with a cleared remainder. frameErr is 1 for exactly the cycle in which that symbol is echoed.
- R8: Any input during the 14 parity cycles, start strobe included, is ignored. It does not change the check symbols and produces no extra output.
- R9: Cycles with inValid=0 inside a message are skipped: they produce no output and leave the remainder unchanged.
- R10: A start strobe on the cycle right after the last check symbol is sent is accepted. The new codeword's first symbol then directly follows that check symbol on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input symbol qualifier |
| inStart | input | 1 | Marks the first symbol of a codeword (with inValid) |
| inData | input | 10 | Message symbol |
| outValid | output | 1 | Output symbol qualifier |
| outParity | output | 1 | Output symbol is a check symbol |
| outData | output | 10 | Message echo or check symbol |
| frameErr | output | 1 | Start strobe arrived before the message was complete |

## Verification
A wrong value in any remainder stage or feedback multiplier reaches the ports only when the check symbols are sent. That can be up to 514 cycles after the fault. It then shows as nonzero syndromes, or as a mismatch against the fixed test vector. A miscounted message or parity counter shows up sooner, as a shifted or lengthened parity flag run around the 514th symbol. A remainder that is not cleared on a start or restart leaves every check symbol of the next codeword wrong. So each scenario checks the syndromes of every codeword it captures, and also checks where the flags sit, cycle by cycle.

// File: rtl/rs528_encoder_pkg.sv
package rs528_encoder_pkg;

  localparam int SYM_W   = 10;
  localparam int MSG_LEN = 514;
  localparam int PAR_LEN = 14;
  localparam logic [SYM_W:0] FIELD_POLY = 11'h409;  // x^10 + x^3 + 1

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [PAR_LEN:0][SYM_W-1:0] genVec_t;
  typedef logic [PAR_LEN-1:0][SYM_W-1:0] remVec_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;  // take inData into the codeword
    logic clear;   // start from a zero remainder
    logic shift;   // shift out one check symbol
  } dpCtrl_t;

  // general field product, used only on constants or at elaboration
  function automatic sym_t gfMul(sym_t a, sym_t b);
    sym_t acc;
    sym_t x;
    acc = '0;
    x = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc ^= x;
      x = x[SYM_W-1] ? ((x << 1) ^ FIELD_POLY[SYM_W-1:0]) : (x << 1);
    end
    return acc;
  endfunction

  // generator = product over j of (x + alpha^j), j = 0 .. PAR_LEN-1
  function automatic genVec_t genPoly();
    genVec_t g;
    sym_t root;
    g = '0;
    g[0] = sym_t'(1);
    root = sym_t'(1);
    for (int j = 0; j < PAR_LEN; j++) begin
      for (int i = PAR_LEN; i > 0; i--) g[i] = g[i-1] ^ gfMul(g[i], root);
      g[0] = gfMul(g[0], root);
      root = gfMul(root, sym_t'(2));
    end
    return g;
  endfunction

endpackage

// File: rtl/rs528_encoder_ctrl.sv
module rs528_encoder_ctrl
  import rs528_encoder_pkg::*;
#(
  parameter int MSG_CNT = MSG_LEN,
  parameter int PAR_CNT = PAR_LEN
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    inStart,
  output dpCtrl_t ctlStb,
  output logic    frameErr
);

  localparam int CNT_W = $clog2(MSG_CNT + 1);
  localparam int PC_W  = (PAR_CNT > 1) ? $clog2(PAR_CNT) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_MSG, ST_PAR} state_t;

  state_t           state;
  logic [CNT_W-1:0] msgCnt;
  logic [PC_W-1:0]  parCnt;

  always_comb begin
    ctlStb.accept = inValid && ((state == ST_IDLE) ? inStart : (state == ST_MSG));
    ctlStb.clear  = ctlStb.accept && inStart;
    ctlStb.shift  = (state == ST_PAR);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      msgCnt   <= '0;
      parCnt   <= '0;
      frameErr <= 1'b0;
    end else begin
      frameErr <= (state == ST_MSG) && inValid && inStart;
      unique case (state)
        ST_IDLE: begin
          if (ctlStb.accept) begin
            state  <= ST_MSG;
            msgCnt <= CNT_W'(1);
          end
        end
        ST_MSG: begin
          if (ctlStb.accept) begin
            if (inStart) begin
              msgCnt <= CNT_W'(1);
            end else if (msgCnt == CNT_W'(MSG_CNT - 1)) begin
              state  <= ST_PAR;
              parCnt <= '0;
              msgCnt <= '0;
            end else begin
              msgCnt <= msgCnt + CNT_W'(1);
            end
          end
        end
        ST_PAR: begin
          if (parCnt == PC_W'(PAR_CNT - 1)) begin
            state  <= ST_IDLE;
            parCnt <= '0;
          end else begin
            parCnt <= parCnt + PC_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rs528_encoder_datapath.sv
module rs528_encoder_datapath
  import rs528_encoder_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpCtrl_t ctlStb,
  input  sym_t    inData,
  output logic    outValid,
  output logic    outParity,
  output sym_t    outData
);

  localparam genVec_t GEN = genPoly();

  remVec_t remReg;
  remVec_t remNext;
  sym_t    topSym;
  sym_t    feedback;

  assign topSym   = ctlStb.clear ? '0 : remReg[PAR_LEN-1];
  assign feedback = ctlStb.shift ? '0 : (inData ^ topSym);

  // one constant multiplier per generator coefficient
  for (genvar i = 0; i < PAR_LEN; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign remNext[i] = gfMul(feedback, GEN[i]);
    end else begin : g_rest
      assign remNext[i] = (ctlStb.clear ? '0 : remReg[i-1]) ^ gfMul(feedback, GEN[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remReg    <= '0;
      outValid  <= 1'b0;
      outParity <= 1'b0;
      outData   <= '0;
    end else begin
      outValid  <= ctlStb.accept || ctlStb.shift;
      outParity <= ctlStb.shift;
      if (ctlStb.accept || ctlStb.shift) remReg <= remNext;
      if (ctlStb.shift)       outData <= remReg[PAR_LEN-1];
      else if (ctlStb.accept) outData <= inData;
    end
  end

endmodule

// File: rtl/rs528_encoder.sv
module rs528_encoder
  import rs528_encoder_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inStart,
  input  logic [SYM_W-1:0] inData,
  output logic             outValid,
  output logic             outParity,
  output logic [SYM_W-1:0] outData,
  output logic             frameErr
);

  dpCtrl_t ctlStb;

  rs528_encoder_ctrl #(
    .MSG_CNT(MSG_LEN),
    .PAR_CNT(PAR_LEN)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inStart (inStart),
    .ctlStb  (ctlStb),
    .frameErr(frameErr)
  );

  rs528_encoder_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctlStb   (ctlStb),
    .inData   (inData),
    .outValid (outValid),
    .outParity(outParity),
    .outData  (outData)
  );

endmodule

// File: rtl/rs528_encoder_checker.sv
module rs528_encoder_checker
  import rs528_encoder_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [SYM_W-1:0] inData,
  input logic             acceptStb,
  input logic             outValid,
  input logic             outParity,
  input logic [SYM_W-1:0] outData,
  input logic             frameErr
);

  logic [7:0] parRun;

  always_ff @(posedge clk) begin
    if (!rstN) parRun <= '0;
    else       parRun <= outParity ? parRun + 8'd1 : 8'd0;
  end

  AST_ECHO_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    $past(acceptStb) |-> (outValid && !outParity && outData == $past(inData))); // R2

  AST_PARITY_FLAG_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outParity |-> outValid); // R3

  AST_PARITY_NO_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outParity) |-> $past(outValid)); // R3

  AST_PARITY_RUN_MAX: assert property (@(posedge clk) disable iff (!rstN)
    parRun <= 8'(PAR_LEN)); // R3

  AST_PARITY_RUN_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outParity) |-> parRun == 8'(PAR_LEN)); // R3

  AST_FRAME_ERR_ON_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> (outValid && !outParity)); // R7

endmodule

bind rs528_encoder rs528_encoder_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inData   (inData),
  .acceptStb(ctlStb.accept),
  .outValid (outValid),
  .outParity(outParity),
  .outData  (outData),
  .frameErr (frameErr)
);

// File: tb/rs528_encoder_bench.sv
module rs528_encoder_bench;

  localparam int NMSG = 514;
  localparam int NPAR = 14;
  localparam int NCW  = NMSG + NPAR;
  localparam int CAP  = 2048;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       inStart = 1'b0;
  logic [9:0] inData = '0;
  logic       outValid, outParity, frameErr;
  logic [9:0] outData;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int capN = 0;
  logic [9:0] capData [CAP];
  logic       capPar  [CAP];
  logic       capErr  [CAP];
  int         capCyc  [CAP];
  logic [9:0] msg [NMSG];

  logic [9:0] vecPar [NPAR] = '{10'h1c3, 10'h3b8, 10'h2a2, 10'h08c, 10'h21b, 10'h11f, 10'h1cc,
                                10'h1b6, 10'h22f, 10'h373, 10'h21e, 10'h375, 10'h3a2, 10'h0bf};

  rs528_encoder u_rs528_encoder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStart(inStart), .inData(inData),
    .outValid(outValid), .outParity(outParity), .outData(outData), .frameErr(frameErr)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rstN && outValid && capN < CAP) begin
      capData[capN] = outData;
      capPar[capN]  = outParity;
      capErr[capN]  = frameErr;
      capCyc[capN]  = cyc;
      capN++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] fmul(logic [9:0] a, logic [9:0] b);
    logic [19:0] p;
    p = '0;
    for (int i = 0; i < 10; i++) if (a[i]) p ^= (20'(b) << i);
    for (int i = 19; i >= 10; i--) if (p[i]) p ^= (20'h409 << (i - 10));
    return p[9:0];
  endfunction

  // number of nonzero syndromes of the captured codeword starting at b
  function automatic int badSyndromes(int b);
    logic [9:0] root;
    logic [9:0] s;
    int bad;
    root = 10'd1;
    bad = 0;
    for (int j = 0; j < NPAR; j++) begin
      s = '0;
      for (int k = 0; k < NCW; k++) s = fmul(s, root) ^ capData[b + k];
      if (s != 0) bad++;
      root = fmul(root, 10'd2);
    end
    return bad;
  endfunction

  task automatic drive(input bit v, input bit s, input logic [9:0] d);
    @(negedge clk);
    inValid = v;
    inStart = s;
    inData  = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 10'h0);
  endtask

  task automatic sendMsg(input int gapEvery);
    for (int i = 0; i < NMSG; i++) begin
      if (gapEvery > 0 && (i % gapEvery) == 3) drive(1'b0, 1'b1, 10'h155);
      drive(1'b1, i == 0, msg[i]);
    end
  endtask

  // echo, flag position and syndromes of one codeword captured at b
  task automatic checkWord(input int b, input string tag);
    int badEcho;
    int badFlag;
    badEcho = 0;
    badFlag = 0;
    for (int i = 0; i < NMSG; i++) if (capData[b + i] != msg[i]) badEcho++;
    for (int i = 0; i < NCW; i++) if (capPar[b + i] != (i >= NMSG)) badFlag++;
    check(badEcho == 0, {tag, " R2 echo"}, badEcho, 0);
    check(badFlag == 0, {tag, " R3 parity flag position"}, badFlag, 0);
    check(capCyc[b + NCW - 1] - capCyc[b + NMSG - 1] == NPAR, {tag, " R3 parity contiguous"},
          capCyc[b + NCW - 1] - capCyc[b + NMSG - 1], NPAR);
    check(badSyndromes(b) == 0, {tag, " R4 syndromes"}, badSyndromes(b), 0);
  endtask

  task automatic checkVector(input int b, input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < NPAR; i++) begin
      if (capData[b + NMSG + i] != vecPar[i]) begin
        if (bad == 0)
          $display("FAIL %s check symbol %0d actual=%0h expected=%0h", tag, i,
                   capData[b + NMSG + i], vecPar[i]);
        bad++;
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  task automatic testReset();
    check(outValid == 0 && outParity == 0 && frameErr == 0, "R1 reset outputs",
          {outValid, outParity, frameErr}, 0);
  endtask

  task automatic testVector();
    capN = 0;
    for (int i = 0; i < NMSG; i++) msg[i] = 10'(1023 - i);
    sendMsg(0);
    idle(20);
    check(capN == NCW, "R3 vector output count", capN, NCW);
    checkWord(0, "vector");
    checkVector(0, "R5 vector parity");
  endtask

  task automatic testZero();
    int nz;
    capN = 0;
    nz = 0;
    for (int i = 0; i < NMSG; i++) msg[i] = '0;
    sendMsg(0);
    idle(20);
    for (int i = NMSG; i < NCW; i++) if (capData[i] != 0) nz++;
    check(nz == 0, "R4 zero message gives zero parity", nz, 0);
  endtask

  task automatic testGaps();
    capN = 0;
    for (int i = 0; i < NMSG; i++) msg[i] = 10'($urandom);
    sendMsg(7);
    idle(20);
    check(capN == NCW, "R9 gaps output count", capN, NCW);
    checkWord(0, "R9 gaps");
  endtask

  task automatic testIdleIgnored();
    capN = 0;
    for (int i = 0; i < 10; i++) drive(1'b1, 1'b0, 10'(i));
    idle(5);
    check(capN == 0, "R6 symbols without start ignored", capN, 0);
  endtask

  task automatic testFrameErr();
    int extra;
    capN = 0;
    for (int i = 0; i < 100; i++) drive(1'b1, i == 0, 10'(3 * i + 7));
    for (int i = 0; i < NMSG; i++) msg[i] = 10'(1023 - i);
    sendMsg(0);
    idle(20);
    check(capN == 100 + NCW, "R7 restart output count", capN, 100 + NCW);
    check(capErr[100] == 1, "R7 frameErr on restart echo", capErr[100], 1);
    extra = 0;
    for (int i = 0; i < capN; i++) if (i != 100 && capErr[i]) extra++;
    check(extra == 0, "R7 frameErr only once", extra, 0);
    checkWord(100, "R7 restarted word");
    checkVector(100, "R7 restarted word parity");
  endtask

  task automatic testParityIgnore();
    capN = 0;
    for (int i = 0; i < NMSG; i++) msg[i] = 10'(1023 - i);
    sendMsg(0);
    for (int i = 0; i < NPAR; i++) drive(1'b1, 1'b1, 10'h3ff - 10'(i));
    idle(20);
    check(capN == NCW, "R8 no extra output during parity", capN, NCW);
    checkVector(0, "R8 parity unchanged by input");
  endtask

  task automatic testBackToBack();
    capN = 0;
    for (int i = 0; i < NMSG; i++) msg[i] = 10'(1023 - i);
    sendMsg(0);
    idle(NPAR);
    checkVector(0, "R10 first word parity");
    for (int i = 0; i < NMSG; i++) msg[i] = 10'($urandom);
    sendMsg(0);
    idle(20);
    check(capN == 2 * NCW, "R10 two words output count", capN, 2 * NCW);
    check(capCyc[NCW] - capCyc[NCW - 1] == 1, "R10 no gap between words",
          capCyc[NCW] - capCyc[NCW - 1], 1);
    checkWord(NCW, "R10 second word");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testVector();
    testZero();
    testGaps();
    testIdleIgnored();
    testFrameErr();
    testParityIgnore();
    testBackToBack();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule